// File: doc/BRIEF.md
# E3 Frame Alignment Tracker

This block takes a serial E3 line stream, one bit per clock, already decoded from the line code. It looks for the 10-bit frame alignment word 1111010000 at the head of each frame of `FRAME_LEN` bits. The default frame is 1536 bits, and the word fills the first ten bits of the frame. The search is serial. While hunting, every bit position is tried in turn: a failed comparison moves the candidate on by one bit. A candidate that matches must then match again at the same spot in the next two frames, one frame length apart each time. After those three good words in a row the block declares lock. Once locked, it tolerates up to three bad words in a row. The fourth bad word in a row drops lock and restarts the hunt.

The block has three outputs: `in_frame`, its complement `oof`, and a one-cycle `frame_start` strobe. The strobe marks the cycle in which `bit_in` carries the first bit of a frame. While the block is out of frame, the strobe keeps beating at the last locked alignment. It moves to the new alignment only in the cycle after the new lock is declared. Downstream logic can therefore keep demultiplexing on the old framing until a new one is proven.

Top module: `e3_frame_align`

## Requirements
- R1: While `rst_n` is low, and until the first alignment word is found, `oof` is 1, `in_frame` is 0 and `frame_start` is 0.
- R2: The alignment word is 1111010000, with the leftmost bit sent first. A word counts as correct only when the last ten bits received, ending at the current bit, equal this pattern in arrival order.
- R3: While hunting, each bit position is a candidate. A mismatch slides the search by one bit. If the first complete word ends at bit e, and the words ending at e+FRAME_LEN and e+2*FRAME_LEN are also correct, `in_frame` rises in the clock cycle after bit e+2*FRAME_LEN.
- R4: If a confirmation word (the second or third word) is wrong, the block goes back to hunting, starting with the next bit. Lock then needs three new consecutive correct words.
- R5: While in frame, one, two or three consecutive wrong words leave `in_frame` at 1. A single correct word clears the count of bad words.
- R6: The fourth consecutive wrong word while in frame clears `in_frame` in the clock cycle after that word's last bit.
- R7: `frame_start` is 1 for exactly one cycle per frame. That cycle is the one in which `bit_in` carries the first bit of the alignment word. The strobe is never active before the first lock.
- R8: While the block is out of frame, `frame_start` keeps the previous alignment. It switches to the new alignment from the cycle after the new lock is declared.
- R9: `oof` is always the complement of `in_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Decoded serial line bit |
| in_frame | output | 1 | Alignment locked |
| oof | output | 1 | Out of frame (complement of in_frame) |
| frame_start | output | 1 | Strobe in the cycle of the first bit of a frame |

## Verification
Suppose the candidate position counter or the bad-word count holds a wrong value. Then a good word is checked at the wrong bit. That shows up at the ports within one frame: lock is delayed by at least one whole frame, or `in_frame` drops early. A fault in the output alignment counter shifts or doubles the `frame_start` strobe. This is visible within a single frame of the lock, and it also shows during a loss interval as a strobe that leaves the old alignment. The bench therefore compares every cycle of `in_frame`, `oof` and `frame_start` against a position computed arithmetically. It does this for every frame offset, for failures at each confirmation word, and for a realignment to a new offset.

// File: rtl/e3_frame_align.sv
module e3_frame_align #(
  parameter int FRAME_LEN = 1536,
  parameter int FAS_LEN = 10,
  parameter logic [FAS_LEN-1:0] FAS_WORD = 10'b1111010000,
  parameter int LOSS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic in_frame,
  output logic oof,
  output logic frame_start
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam int LW = $clog2(LOSS_LIMIT + 1);
  localparam logic [CW-1:0] POS_LAST = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] POS_CHECK = CW'(FAS_LEN - 1);
  localparam logic [CW-1:0] POS_AFTER = CW'(FAS_LEN);

  typedef enum logic [2:0] {HUNT, CONF1, CONF2, LOCKED, LOSING} state_t;

  state_t state;
  logic [FAS_LEN-2:0] hist;
  logic [CW-1:0] cand_pos, out_pos;
  logic [LW-1:0] bad_cnt;
  logic have_align;

  wire [FAS_LEN-1:0] window = {hist, bit_in};
  wire word_ok  = (window == FAS_WORD);
  wire at_check = (state != HUNT) && (cand_pos == POS_CHECK);
  wire lock_now = (state == CONF2) && at_check && word_ok;

  assign in_frame    = (state == LOCKED) || (state == LOSING);
  assign oof         = ~in_frame;
  assign frame_start = have_align && (out_pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= HUNT;
      hist       <= '0;
      cand_pos   <= '0;
      out_pos    <= '0;
      bad_cnt    <= '0;
      have_align <= 1'b0;
    end else begin
      hist <= window[FAS_LEN-2:0];

      if (state == HUNT && word_ok)
        cand_pos <= POS_AFTER;
      else
        cand_pos <= (cand_pos == POS_LAST) ? '0 : cand_pos + 1'b1;

      if (lock_now) begin
        out_pos    <= POS_AFTER;
        have_align <= 1'b1;
      end else begin
        out_pos <= (out_pos == POS_LAST) ? '0 : out_pos + 1'b1;
      end

      case (state)
        HUNT:   if (word_ok) state <= CONF1;
        CONF1:  if (at_check) state <= word_ok ? CONF2 : HUNT;
        CONF2:  if (at_check) state <= word_ok ? LOCKED : HUNT;
        LOCKED: if (at_check && !word_ok) begin
                  state   <= LOSING;
                  bad_cnt <= LW'(1);
                end
        LOSING: if (at_check) begin
                  if (word_ok) begin
                    state   <= LOCKED;
                    bad_cnt <= '0;
                  end else if (bad_cnt == LW'(LOSS_LIMIT - 1)) begin
                    state   <= HUNT;
                    bad_cnt <= '0;
                  end else begin
                    bad_cnt <= bad_cnt + 1'b1;
                  end
                end
        default: state <= HUNT;
      endcase
    end
  end

  a_r3_lock_after_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> ($past(state) == CONF2) && $past(word_ok));

  a_r4_confirm_miss_hunts: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == CONF1 || state == CONF2) && at_check && !word_ok) |=> (state == HUNT) && !in_frame);

  a_r5_good_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LOSING && at_check && word_ok) |=> (state == LOCKED) && (bad_cnt == '0) && in_frame);

  a_r6_drop_on_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> ($past(bad_cnt) == LW'(LOSS_LIMIT - 1)) && !$past(word_ok));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r8_strobe_held_out_of_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (oof && have_align && !$past(lock_now) && $past(out_pos) == POS_LAST) |-> frame_start);
endmodule

// File: tb/e3_frame_align_test.sv
module e3_frame_align_test;
  localparam int F = 48;
  localparam logic [9:0] FAS = 10'b1111010000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic in_frame, oof, frame_start;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int cur_k1, cur_k2, cur_sh;
  logic [31:0] cur_mask;

  always #4 clk = ~clk;

  e3_frame_align #(.FRAME_LEN(F)) uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
    .in_frame(in_frame), .oof(oof), .frame_start(frame_start)
  );

  function automatic logic gen_bit(input int i);
    int k, j, n;
    logic b;
    k = (i < cur_sh) ? cur_k1 : cur_k2;
    j = (i + 4 * F - k) % F;
    n = (i + 4 * F - k) / F - 4;
    b = (j < 10) ? FAS[9 - j] : (((j - 10) % 2) == 0);
    if (j == 0 && n >= 0 && n < 32 && cur_mask[n]) b = ~b;
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input int i, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, i, act, exp);
    end
  endtask

  task automatic run(input int k1, input int k2, input int sh, input logic [31:0] mask,
                     input int lock1, input int drop, input int lock2, input int ncyc);
    int exp_if, exp_fs, ph;
    cur_k1 = k1; cur_k2 = k2; cur_sh = sh; cur_mask = mask;
    rst_n = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(oof == 1'b1 && in_frame == 1'b0 && frame_start == 1'b0, "R1", i, {oof, in_frame, frame_start}, 3'b100);
        rst_n = 1'b1;
      end
      exp_if = ((i > lock1) && !(drop >= 0 && i > drop)) || (lock2 >= 0 && i > lock2);
      ph = -1;
      if (lock2 >= 0 && i > lock2) ph = k2;
      else if (i > lock1) ph = k1;
      exp_fs = (ph >= 0) ? (((i + 4 * F - ph) % F) == 0) : 0;
      chk(in_frame == exp_if[0], (exp_if != 0) ? "R3/R5 in_frame" : "R4/R6 in_frame", i, in_frame, exp_if);
      chk(oof == ~in_frame, "R9 oof", i, oof, !in_frame);
      chk(frame_start == exp_fs[0], (lock2 >= 0) ? "R8 frame_start" : "R7 frame_start", i, frame_start, exp_fs);
      bit_in = gen_bit(i);
    end
  endtask

  initial begin
    // R2/R3/R7: every frame offset, clean stream, lock after three words
    for (int k = 0; k < F; k++)
      run(k, k, 1 << 30, 32'h0, k + 9 + 2 * F, -1, -1, k + 9 + 4 * F);
    // R4: failed first word, failed first and second confirmation
    run(5, 5, 1 << 30, 32'h1, 14 + 3 * F, -1, -1, 14 + 5 * F);
    run(5, 5, 1 << 30, 32'h2, 14 + 4 * F, -1, -1, 14 + 6 * F);
    run(5, 5, 1 << 30, 32'h4, 14 + 5 * F, -1, -1, 14 + 7 * F);
    // R5: three bad words, one good, three bad, one good: lock held
    run(7, 7, 1 << 30, 32'h0000_03B8, 16 + 2 * F, -1, -1, 16 + 12 * F);
    // R6/R8: alignment moves by 20 bits, four bad words drop lock, strobe held until relock
    run(7, 27, 7 + 3 * F, 32'h0, 16 + 2 * F, 16 + 6 * F, 16 + 8 * F + 20, 16 + 10 * F + 20);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule